// File: doc/BRIEF.md
# Cascadable Display Column Sampling Chain

This block is the digital front end of a column driver for an active-matrix display. It waits in standby until a one-cycle start pulse arrives on its upstream cascade pin. On the next rising clock edge it begins to store grayscale data: three 6-bit words per edge, one word for each of three neighbouring channels, written into a wide sampling register. The channel groups fill in ascending order or descending order, as a direction input selects. When one clock period of the line is left, the block raises a one-cycle carry pulse on its downstream cascade pin. The next driver in the chain can then start capturing on the cycle after this one finishes.

A separate load strobe copies the whole sampling register into a load register. The load register drives every channel code at the same time, so the display can receive a new line while the previous one is still being shown. A mode input chooses between a full line of 309 channels and a reduced line of 300 channels. The reduced line leaves out a fixed block of nine channels in the middle. The two cascade pins each have separate input, output and output-enable signals. The direction setting decides which pin listens and which pin drives.

Top module: `lcdcol_chain`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears both registers to zero, goes to standby and drives both cascade outputs low. Direction then defaults to ascending and line mode to 300 channels.
- R2: A high on the listening cascade input, seen at a rising edge while in standby, arms the block. The first group capture happens on the very next rising edge.
- R3: Each capture stores `pix_i[5:0]`, `pix_i[11:6]` and `pix_i[17:12]` into the three channels of one group, lowest channel first. Channel n (counted from 1) appears on `chan_o[6(n-1)+5 : 6(n-1)]`, with bit 5 weighted 32 and bit 0 weighted 1.
- R4: With `scan_up` high, groups fill from channels 1-3 upward. Pin A listens (`cas_a_oe`=0) and pin B drives (`cas_b_oe`=1).
- R5: With `scan_up` low, groups fill from channels 307-309 downward. Pin B listens (`cas_b_oe`=0) and pin A drives (`cas_a_oe`=1).
- R6: A full line takes exactly 103 captures and a reduced line exactly 100. After the last capture the block is back in standby, and data presented afterwards changes nothing.
- R7: The driving cascade output is high for exactly one clock period. It rises at the edge of the second-to-last capture and falls at the edge of the last capture.
- R8: With `short_line` high, channels 151-159 are never written and keep their earlier contents. The 100 captures cover the other 300 channels in order in both directions.
- R9: A high on `load_i` at a rising edge copies the entire sampling register to `chan_o`. With `load_i` low, `chan_o` does not change.
- R10: A start pulse that arrives while a line is being captured is ignored. It does not change the capture order, the line length or the carry timing.
- R11: `scan_up` and `short_line` are sampled only in standby. Changing them during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_up | input | 1 | 1 = ascending fill, 0 = descending fill |
| short_line | input | 1 | 1 = 300-channel line, 0 = 309-channel line |
| pix_i | input | 18 | Three 6-bit grayscale words for one group |
| load_i | input | 1 | Copy sampling register to outputs |
| cas_a_i | input | 1 | Cascade pin A input level |
| cas_a_o | output | 1 | Cascade pin A output level |
| cas_a_oe | output | 1 | Cascade pin A output enable |
| cas_b_i | input | 1 | Cascade pin B input level |
| cas_b_o | output | 1 | Cascade pin B output level |
| cas_b_oe | output | 1 | Cascade pin B output enable |
| chan_o | output | 1854 | 309 channel codes, 6 bits each |

## Verification
Several rules are checked on every cycle by the assertions:
- the carry pulse is one cycle long and lines up with the second-to-last position;
- the capture position stays inside the line length;
- configuration stays stable while a line is filling;
- an extra start pulse during a fill leaves the count unchanged;
- the skipped groups are never written;
- the load register holds between strobes.

Other properties can only be shown by the bench's scenarios against its scoreboard of expected channel codes: the exact group order in each direction and mode, the within-group word placement, the retained contents of the skipped middle channels, and the fact that data after the line's end is ignored.

// File: rtl/lcdcol_pkg.sv
`timescale 1ns/1ps
package lcdcol_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} fill_st_t;

   typedef struct packed {
      logic dir_up;
      logic short_line;
   } line_cfg_t;
endpackage

// File: rtl/lcdcol_seq.sv
`timescale 1ns/1ps
module lcdcol_seq
   import lcdcol_pkg::*;
#(
   parameter int N_GRP   = 103,
   parameter int SKIP_G0 = 50,
   parameter int SKIP_GN = 3,
   localparam int CW     = $clog2(N_GRP + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_up_i,
   input  logic          short_i,
   input  logic          en_a_i,
   input  logic          en_b_i,
   output logic          en_a_o,
   output logic          en_a_oe,
   output logic          en_b_o,
   output logic          en_b_oe,
   output logic          wr_en_o,
   output logic [CW-1:0] wr_grp_o
);
   localparam int NCAP_FULL  = N_GRP;
   localparam int NCAP_SHORT = N_GRP - SKIP_GN;

   fill_st_t     st;
   line_cfg_t    cfg;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last_pos;
   logic [CW-1:0] pos_q;
   logic          carry_q;
   logic          start;

   assign start    = cfg.dir_up ? en_a_i : en_b_i;
   assign last_pos = cfg.short_line ? CW'(NCAP_SHORT - 1) : CW'(NCAP_FULL - 1);
   assign pos_q    = cfg.dir_up ? cnt : (last_pos - cnt);
   assign wr_en_o  = (st == ST_FILL);

   generate
      if (SKIP_GN > 0) begin : g_skip
         assign wr_grp_o = (cfg.short_line && pos_q >= CW'(SKIP_G0)) ?
                           pos_q + CW'(SKIP_GN) : pos_q;
      end else begin : g_noskip
         assign wr_grp_o = pos_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         cfg     <= '{dir_up: 1'b1, short_line: 1'b1};
         carry_q <= 1'b0;
      end else begin
         carry_q <= (st == ST_FILL) && (cnt == last_pos - CW'(1));
         case (st)
            ST_IDLE: begin
               cfg <= '{dir_up: dir_up_i, short_line: short_i};
               if (start) begin
                  st  <= ST_FILL;
                  cnt <= '0;
               end
            end
            default: begin
               if (cnt == last_pos) st <= ST_IDLE;
               else                 cnt <= cnt + CW'(1);
            end
         endcase
      end
   end

   assign en_a_oe = ~cfg.dir_up;
   assign en_b_oe =  cfg.dir_up;
   assign en_a_o  = carry_q & ~cfg.dir_up;
   assign en_b_o  = carry_q &  cfg.dir_up;

   assert_carry_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      carry_q |=> !carry_q);
   assert_carry_at_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      carry_q |-> (st == ST_FILL && cnt == last_pos));
   assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL) |-> (cnt <= last_pos));
   assert_start_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start) |=> (st == ST_FILL && cnt == '0));
   assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL && cnt != last_pos) |=> (st == ST_FILL && cnt == $past(cnt) + CW'(1)));
   assert_cfg_static_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL) |=> $stable(cfg));
   assert_pin_roles_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a_oe != en_b_oe) && !(en_a_o && !en_a_oe) && !(en_b_o && !en_b_oe));
   assert_skip_hole_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && cfg.short_line) |->
         !(int'(wr_grp_o) >= SKIP_G0 && int'(wr_grp_o) < SKIP_G0 + SKIP_GN));
endmodule

// File: rtl/lcdcol_sample.sv
`timescale 1ns/1ps
module lcdcol_sample #(
   parameter int N_GRP  = 103,
   parameter int GRP_CH = 3,
   parameter int WORD_W = 6,
   localparam int CW    = $clog2(N_GRP + 1),
   localparam int GW    = GRP_CH * WORD_W,
   localparam int TW    = N_GRP * GW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_grp,
   input  logic [GW-1:0] pix,
   output logic [TW-1:0] samp
);
   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      always_ff @(posedge clk) begin
         if (!rst_n)                            samp[g*GW +: GW] <= '0;
         else if (wr_en && wr_grp == CW'(g))    samp[g*GW +: GW] <= pix;
      end
   end

   assert_group_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (samp[$past(wr_grp)*GW +: GW] == $past(pix)));
endmodule

// File: rtl/lcdcol_hold.sv
`timescale 1ns/1ps
module lcdcol_hold #(
   parameter int W = 1854
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));
   assert_hold_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(d)));
endmodule

// File: rtl/lcdcol_chain.sv
`timescale 1ns/1ps
module lcdcol_chain #(
   parameter int CH_TOTAL   = 309,
   parameter int WORD_W     = 6,
   parameter int GRP_CH     = 3,
   parameter int SKIP_FIRST = 150,
   parameter int SKIP_CH    = 9,
   localparam int N_GRP     = CH_TOTAL / GRP_CH,
   localparam int SKIP_G0   = SKIP_FIRST / GRP_CH,
   localparam int SKIP_GN   = SKIP_CH / GRP_CH,
   localparam int CW        = $clog2(N_GRP + 1),
   localparam int GW        = GRP_CH * WORD_W,
   localparam int TW        = CH_TOTAL * WORD_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scan_up,
   input  logic          short_line,
   input  logic [GW-1:0] pix_i,
   input  logic          load_i,
   input  logic          cas_a_i,
   output logic          cas_a_o,
   output logic          cas_a_oe,
   input  logic          cas_b_i,
   output logic          cas_b_o,
   output logic          cas_b_oe,
   output logic [TW-1:0] chan_o
);
   if (CH_TOTAL % GRP_CH != 0) begin : g_chk_total
      $error("CH_TOTAL must be a multiple of GRP_CH");
   end
   if (SKIP_FIRST % GRP_CH != 0 || SKIP_CH % GRP_CH != 0) begin : g_chk_skip
      $error("skipped block must be group aligned");
   end
   if (SKIP_G0 + SKIP_GN > N_GRP || N_GRP - SKIP_GN < 2) begin : g_chk_fit
      $error("skipped block must fit and leave at least two groups");
   end

   logic          wr_en;
   logic [CW-1:0] wr_grp;
   logic [TW-1:0] samp;

   lcdcol_seq #(
      .N_GRP(N_GRP), .SKIP_G0(SKIP_G0), .SKIP_GN(SKIP_GN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .dir_up_i(scan_up), .short_i(short_line),
      .en_a_i(cas_a_i), .en_b_i(cas_b_i),
      .en_a_o(cas_a_o), .en_a_oe(cas_a_oe), .en_b_o(cas_b_o), .en_b_oe(cas_b_oe),
      .wr_en_o(wr_en), .wr_grp_o(wr_grp)
   );

   lcdcol_sample #(
      .N_GRP(N_GRP), .GRP_CH(GRP_CH), .WORD_W(WORD_W)
   ) u_samp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
      .pix(pix_i), .samp(samp)
   );

   lcdcol_hold #(.W(TW)) u_hold (
      .clk(clk), .rst_n(rst_n), .ld(load_i), .d(samp), .q(chan_o)
   );
endmodule

// File: tb/lcdcol_chain_tb.sv
`timescale 1ns/1ps
module lcdcol_chain_tb;
   localparam int NCH = 309;
   localparam int WW  = 6;
   localparam int TW  = NCH * WW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_up = 1'b1;
   logic          short_line = 1'b1;
   logic [17:0]   pix_i = '0;
   logic          load_i = 1'b0;
   logic          cas_a_i = 1'b0, cas_b_i = 1'b0;
   logic          cas_a_o, cas_a_oe, cas_b_o, cas_b_oe;
   logic [TW-1:0] chan_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [TW-1:0] exp_samp = '0;
   logic [TW-1:0] last_loaded = '0;
   logic [TW-1:0] sb_q[$];
   logic          ld_q = 1'b0;

   always #2.5 clk = ~clk;

   lcdcol_chain u_dut (
      .clk(clk), .rst_n(rst_n), .scan_up(scan_up), .short_line(short_line),
      .pix_i(pix_i), .load_i(load_i),
      .cas_a_i(cas_a_i), .cas_a_o(cas_a_o), .cas_a_oe(cas_a_oe),
      .cas_b_i(cas_b_i), .cas_b_o(cas_b_o), .cas_b_oe(cas_b_oe),
      .chan_o(chan_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // group visited at position p, built by walking the channel list
   function automatic int grp_at(input bit up, input bit shortm, input int p);
      int n = 0;
      for (int i = 0; i < NCH / 3; i++) begin
         int g = up ? i : (NCH / 3 - 1 - i);
         if (shortm && g >= 50 && g <= 52) continue;
         if (n == p) return g;
         n++;
      end
      return -1;
   endfunction

   function automatic logic [5:0] word_of(input int seed, input int p, input int k);
      return 6'((seed * 13 + p * 5 + k * 23 + 7) % 64);
   endfunction

   // scoreboard compare: first mismatching channel reported
   task automatic sb_compare(input logic [TW-1:0] expv);
      checks++;
      if (chan_o !== expv) begin
         for (int c = 0; c < NCH; c++) begin
            if (chan_o[c*WW +: WW] !== expv[c*WW +: WW]) begin
               failures++;
               $display("FAIL %s channel %0d actual=%0d expected=%0d",
                        (c >= 150 && c < 159) ? "R8" : "R3 R2 R10 R11",
                        c + 1, chan_o[c*WW +: WW], expv[c*WW +: WW]);
               break;
            end
         end
      end
   endtask

   always @(posedge clk) ld_q <= load_i;

   // monitor: pops one expected image per observed load
   always @(negedge clk) begin
      if (ld_q) begin
         if (sb_q.size() == 0) chk(1'b0, "R9", "unexpected load result", 0, 1);
         else sb_compare(sb_q.pop_front());
      end
   end

   task automatic do_load();
      load_i = 1'b1;
      sb_q.push_back(exp_samp);
      last_loaded = exp_samp;
      @(negedge clk);
      load_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_line(input bit up, input bit shortm, input int seed, input bit poke);
      int ncap = shortm ? 100 : 103;
      scan_up = up;
      short_line = shortm;
      @(negedge clk);
      @(negedge clk);
      // R4 / R5 pin roles
      chk(cas_a_oe == !up && cas_b_oe == up, up ? "R4" : "R5", "pin A oe",
          int'(cas_a_oe), int'(!up));
      if (up) cas_a_i = 1'b1; else cas_b_i = 1'b1;
      @(negedge clk);
      cas_a_i = 1'b0;
      cas_b_i = 1'b0;
      for (int p = 0; p < ncap; p++) begin
         int g = grp_at(up, shortm, p);
         cas_a_i = 1'b0;
         cas_b_i = 1'b0;
         for (int k = 0; k < 3; k++) begin
            pix_i[k*6 +: 6] = word_of(seed, p, k);
            exp_samp[(g*3 + k)*WW +: WW] = word_of(seed, p, k);
         end
         if (poke && p == 10) begin   // R10: start pulse mid-line
            if (up) cas_a_i = 1'b1; else cas_b_i = 1'b1;
         end
         if (poke && p == 20) begin   // R11: config flip mid-line
            scan_up = !up;
            short_line = !shortm;
         end
         if (poke && p == 60) begin
            scan_up = up;
            short_line = shortm;
         end
         @(negedge clk);
         chk((up ? cas_b_o : cas_a_o) == (p == ncap - 2), "R7", "carry level",
             int'(up ? cas_b_o : cas_a_o), int'(p == ncap - 2));
      end
      // R6: data after the last capture must be dropped
      for (int j = 0; j < 3; j++) begin
         pix_i = 18'h2AAAA ^ 18'(j * 977);
         @(negedge clk);
      end
      chk(chan_o == last_loaded, "R9", "outputs moved without load", 0, 0);
      do_load();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(chan_o == '0, "R1", "chan_o zero", int'(chan_o[5:0]), 0);
      chk(cas_a_o == 1'b0 && cas_b_o == 1'b0, "R1", "carry low",
          int'(cas_b_o), 0);
      chk(cas_b_oe == 1'b1 && cas_a_oe == 1'b0, "R1", "default ascending roles",
          int'(cas_b_oe), 1);
      rst_n = 1'b1;
      @(negedge clk);
      run_line(1'b1, 1'b0, 1, 1'b0);   // R4 R3 full ascending
      run_line(1'b0, 1'b0, 2, 1'b1);   // R5 R10 R11 full descending
      run_line(1'b1, 1'b1, 3, 1'b0);   // R8 short ascending, middle keeps line 2
      run_line(1'b0, 1'b1, 4, 1'b1);   // R8 R6 short descending with pokes
      do_load();                       // R9 repeated load gives same image
      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R9", "scoreboard drained", sb_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule